// File: doc/BRIEF.md
# LPC DMA Peripheral Cycle Responder

This block is the peripheral end of a DMA cycle on the 4-bit multiplexed LPC bus. It watches the frame strobe and the nibble bus for a cycle start. It then decodes the DMA cycle type and direction, the channel with its terminal-count bit, and the transfer size. After that it runs one of two data paths. In the read path, the host sends bytes to the peripheral. In the write path, the peripheral sends bytes to the host. The block drives the SYNC codes, the data nibbles and the turn-around nibbles itself, and it provides the output enable for the bus buffer.

On the local side, a channel mask says which channels this device has asked for. The sink of read bytes and the source of write bytes share one strobe-style handshake. The local logic chooses the SYNC code for each byte with two inputs: one asks for the request to end, and one reports an error. A ready input holds the bus in wait states until the local side can take or give a byte. A terminal-count pulse marks the byte that completes the granted size, when the host flagged terminal count.

Top module: `lpc_dma_responder`

## Requirements
- R1: After reset, and whenever no cycle is in progress, `lad_oe`, `rd_valid`, `wr_take` and `tc_out` are low.
- R2: A cycle starts on the clock after the last clock in which `frame_n` is low with `lad_in` = 0000. The next nibble is the cycle type. It is a DMA cycle only if bits [3:2] = 10. Bit 1 selects write (1) or read (0), and bit 0 is ignored. Any other cycle type is left alone.
- R3: The channel nibble carries the channel in bits [2:0] and terminal count in bit 3. If the channel is 4, or if its `chan_req` bit (bit n for channel n) is clear, the cycle is ignored and the bus is never driven.
- R4: The size nibble uses bits [1:0]: 00 means 1 byte, 01 means 2 bytes, 11 means 4 bytes, and 10 means the cycle is ignored. Bits [3:2] have no effect.
- R5: On a read, each byte arrives as two nibbles, low nibble first. Bytes arrive least significant first. Each byte appears on `rd_data` with a one-clock `rd_valid` in the clock where the final SYNC is driven.
- R6: A read byte takes this sequence: two data clocks, two host turn-around clocks, SYNC, then one clock of 1111 with `lad_oe` high, then one clock released. The next byte follows immediately.
- R7: A write cycle has two host turn-around clocks after the size nibble. Each byte is then a SYNC clock followed by the low and high nibbles of the byte, which is sampled from `wr_data` in its SYNC clock (`wr_take` high). After the final byte there is one clock of 1111 and then one released clock.
- R8: While `loc_ready` is low in a SYNC clock, the block drives 0101 and stays in SYNC.
- R9: The final SYNC code is 1010 if `fault_req` is high. Otherwise it is 0000 if `end_req` is high, and 1001 if neither is high.
- R10: A final code of 0000 or 1010 on a byte before the last one ends the cycle after that byte. On a read, the end comes after its turn-around. On a write, the end comes after its data, followed by the turn-around.
- R11: `tc_out` pulses together with the byte strobe of the last byte of the granted size, and only if the terminal-count bit was set. It never pulses on a cycle that ended early.
- R12: If `frame_n` goes low in the middle of a cycle, `lad_oe` drops in that same clock and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Active-low cycle frame strobe |
| lad_in | input | 4 | Nibble bus as received |
| lad_out | output | 4 | Nibble to drive onto the bus |
| lad_oe | output | 1 | Drive enable for the bus buffer |
| chan_req | input | 8 | One bit per channel that this device has requested |
| loc_ready | input | 1 | Local side can complete the current byte |
| end_req | input | 1 | Ask for the DMA request to end with this byte |
| fault_req | input | 1 | Report an error with this byte (ends the request) |
| rd_data | output | 8 | Byte received on a read |
| rd_valid | output | 1 | `rd_data` is accepted this clock |
| wr_data | input | 8 | Byte to send on a write |
| wr_take | output | 1 | `wr_data` is sampled this clock |
| tc_out | output | 1 | Terminal count reached with this byte |

## Verification
An internal fault shows up at the ports within one byte slot. A bad state step moves the SYNC, the 1111 nibble or the release clock by at least one cycle. A bad byte counter or stop flag adds or drops a whole SYNC/data group. A terminal-count flag that is latched wrong shows up as a missing or spurious `tc_out` on the last byte. The bench compares every output on every clock against a per-cycle model. It runs reads and writes of each size, wait states, all three final codes, early ends, ignored channels, ignored sizes and cycle types, and an abort. Because of this, a divergence is reported in the very clock where it first appears.

// File: rtl/lpc_dma_responder.sv
module lpc_dma_responder #(
  parameter int RSV_CH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic [3:0] lad_in,
  output logic [3:0] lad_out,
  output logic       lad_oe,
  input  logic [7:0] chan_req,
  input  logic       loc_ready,
  input  logic       end_req,
  input  logic       fault_req,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  input  logic [7:0] wr_data,
  output logic       wr_take,
  output logic       tc_out
);

  typedef enum logic [3:0] {
    S_IDLE, S_CHAN, S_SIZE, S_RLO, S_RHI, S_HT1, S_HT2,
    S_RSYN, S_PT1, S_PT2, S_WSYN, S_WLO, S_WHI
  } st_t;

  localparam logic [3:0] SY_WAIT = 4'h5;
  localparam logic [3:0] SY_DONE = 4'h0;
  localparam logic [3:0] SY_ERR  = 4'hA;
  localparam logic [3:0] SY_MORE = 4'h9;
  localparam logic [2:0] RSV     = 3'(RSV_CH);

  st_t        st;
  logic       st_pend, dir_wr, tc_l, stop;
  logic [1:0] idx, nlast;
  logic [7:0] bsh;

  logic [3:0] fin;
  logic       in_sync, hs, last_now;

  assign fin      = fault_req ? SY_ERR : (end_req ? SY_DONE : SY_MORE);
  assign in_sync  = (st == S_RSYN) || (st == S_WSYN);
  assign hs       = in_sync && loc_ready && frame_n;
  assign last_now = (idx == nlast) || (fin != SY_MORE);

  assign lad_oe   = frame_n && (in_sync || st == S_PT1 || st == S_WLO || st == S_WHI);
  assign lad_out  = in_sync       ? (loc_ready ? fin : SY_WAIT) :
                    (st == S_WLO) ? bsh[3:0] :
                    (st == S_WHI) ? bsh[7:4] :
                    (st == S_PT1) ? 4'hF : 4'h0;
  assign rd_data  = bsh;
  assign rd_valid = hs && !dir_wr;
  assign wr_take  = hs && dir_wr;
  assign tc_out   = hs && tc_l && (idx == nlast);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      st_pend <= 1'b0;
      dir_wr  <= 1'b0;
      tc_l    <= 1'b0;
      stop    <= 1'b0;
      idx     <= '0;
      nlast   <= '0;
      bsh     <= '0;
    end else if (!frame_n) begin
      st      <= S_IDLE;
      st_pend <= (lad_in == 4'h0);
    end else begin
      st_pend <= 1'b0;
      case (st)
        S_IDLE: if (st_pend && lad_in[3:2] == 2'b10) begin
          dir_wr <= lad_in[1];
          st     <= S_CHAN;
        end
        S_CHAN: begin
          tc_l <= lad_in[3];
          st   <= (lad_in[2:0] != RSV && chan_req[lad_in[2:0]]) ? S_SIZE : S_IDLE;
        end
        S_SIZE: begin
          idx  <= '0;
          stop <= 1'b0;
          case (lad_in[1:0])
            2'b00:   nlast <= 2'd0;
            2'b01:   nlast <= 2'd1;
            default: nlast <= 2'd3;
          endcase
          if (lad_in[1:0] == 2'b10) st <= S_IDLE;
          else                      st <= dir_wr ? S_HT1 : S_RLO;
        end
        S_RLO: begin
          bsh[3:0] <= lad_in;
          st       <= S_RHI;
        end
        S_RHI: begin
          bsh[7:4] <= lad_in;
          st       <= S_HT1;
        end
        S_HT1: st <= S_HT2;
        S_HT2: st <= dir_wr ? S_WSYN : S_RSYN;
        S_RSYN: if (loc_ready) begin
          stop <= last_now;
          st   <= S_PT1;
        end
        S_PT1: st <= S_PT2;
        S_PT2: begin
          if (dir_wr || stop) st <= S_IDLE;
          else begin
            idx <= idx + 2'd1;
            st  <= S_RLO;
          end
        end
        S_WSYN: if (loc_ready) begin
          bsh  <= wr_data;
          stop <= last_now;
          st   <= S_WLO;
        end
        S_WLO: st <= S_WHI;
        S_WHI: begin
          if (stop) st <= S_PT1;
          else begin
            idx <= idx + 2'd1;
            st  <= S_WSYN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lpc_dma_responder_chk.sv
module lpc_dma_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic [3:0] lad_out,
  input logic       lad_oe,
  input logic       rd_valid,
  input logic       wr_take,
  input logic       tc_out
);

  p_abort_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !lad_oe);

  p_tar_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lad_oe) && frame_n) |-> ($past(lad_out) == 4'hF));

  p_rd_then_tar_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> ((lad_oe && lad_out == 4'hF) || !frame_n));

  p_ack_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wr_take) |-> (lad_oe && (lad_out == 4'h0 || lad_out == 4'h9 || lad_out == 4'hA)));

  p_wr_data_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> (lad_oe || !frame_n));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_take));

  p_tc_with_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |-> (rd_valid || wr_take));

endmodule

bind lpc_dma_responder lpc_dma_responder_chk u_chk (.*);

// File: tb/lpc_dma_responder_tb.sv
module lpc_dma_responder_tb;
  localparam int PER = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_n = 1'b1;
  logic [3:0] lad_in = 4'hF;
  logic [3:0] lad_out;
  logic       lad_oe;
  logic [7:0] chan_req = 8'b1111_0110;
  logic       loc_ready = 1'b1;
  logic       end_req = 1'b0;
  logic       fault_req = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [7:0] wr_data = 8'h00;
  logic       wr_take;
  logic       tc_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(PER/2) clk = ~clk;

  lpc_dma_responder u_dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .chan_req(chan_req),
    .loc_ready(loc_ready), .end_req(end_req), .fault_req(fault_req),
    .rd_data(rd_data), .rd_valid(rd_valid), .wr_data(wr_data),
    .wr_take(wr_take), .tc_out(tc_out)
  );

  task automatic step(input logic fr, input logic [3:0] l, input logic rdy,
                      input logic eo, input logic [3:0] el, input logic erv,
                      input logic [7:0] erd, input logic ewt, input logic etc,
                      input string tag);
    frame_n   = fr;
    lad_in    = l;
    loc_ready = rdy;
    @(negedge clk);
    checks++;
    if (lad_oe !== eo || (eo && lad_out !== el) || rd_valid !== erv ||
        (erv && rd_data !== erd) || wr_take !== ewt || tc_out !== etc) begin
      fails++;
      $display("FAIL %s t=%0t: oe=%b lad=%h rv=%b rd=%h wt=%b tc=%b expected oe=%b lad=%h rv=%b rd=%h wt=%b tc=%b",
               tag, $time, lad_oe, lad_out, rd_valid, rd_data, wr_take, tc_out,
               eo, el, erv, erd, ewt, etc);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input logic fr, input logic [3:0] l, input string tag);
    step(fr, l, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 1'b0, 1'b0, tag);
  endtask

  task automatic dma(input logic wr, input logic cb0, input logic [2:0] ch,
                     input logic tcb, input logic [3:0] sz, input logic [31:0] data,
                     input logic [15:0] waits, input logic [3:0] endb,
                     input logic [3:0] errb, input string tag);
    int n;
    logic [3:0] code;
    logic [7:0] b;
    n = (sz[1:0] == 2'b00) ? 1 : (sz[1:0] == 2'b01) ? 2 : (sz[1:0] == 2'b11) ? 4 : 0;
    idle(1'b0, 4'h0, tag);
    idle(1'b1, {2'b10, wr, cb0}, tag);
    idle(1'b1, {tcb, ch}, tag);
    idle(1'b1, sz, tag);
    if (ch == 3'd4 || !chan_req[ch] || n == 0) begin
      for (int k = 0; k < 10; k++) idle(1'b1, 4'(k), {tag, " ignored"});
      return;
    end
    if (wr) begin
      idle(1'b1, 4'hF, tag);
      idle(1'b1, 4'hF, tag);
    end
    for (int i = 0; i < n; i++) begin
      b = data[8*i +: 8];
      end_req   = endb[i];
      fault_req = errb[i];
      code = errb[i] ? 4'hA : (endb[i] ? 4'h0 : 4'h9);
      if (!wr) begin
        idle(1'b1, b[3:0], tag);
        idle(1'b1, b[7:4], tag);
        idle(1'b1, 4'hF, tag);
        idle(1'b1, 4'hF, tag);
      end
      for (int w = 0; w < int'(waits[4*i +: 4]); w++)
        step(1'b1, 4'hF, 1'b0, 1'b1, 4'h5, 1'b0, 8'h00, 1'b0, 1'b0, {tag, " wait"});
      wr_data = b;
      step(1'b1, 4'hF, 1'b1, 1'b1, code, !wr, b, wr, tcb && (i == n - 1), {tag, " sync"});
      wr_data = ~b;
      end_req = 1'b0;
      fault_req = 1'b0;
      if (wr) begin
        step(1'b1, 4'hF, 1'b1, 1'b1, b[3:0], 1'b0, 8'h00, 1'b0, 1'b0, {tag, " wlo"});
        step(1'b1, 4'hF, 1'b1, 1'b1, b[7:4], 1'b0, 8'h00, 1'b0, 1'b0, {tag, " whi"});
      end else begin
        step(1'b1, 4'hF, 1'b1, 1'b1, 4'hF, 1'b0, 8'h00, 1'b0, 1'b0, {tag, " tar"});
        idle(1'b1, 4'hF, {tag, " rel"});
      end
      if (code != 4'h9) break;
    end
    if (wr) begin
      step(1'b1, 4'hF, 1'b1, 1'b1, 4'hF, 1'b0, 8'h00, 1'b0, 1'b0, {tag, " tar"});
      idle(1'b1, 4'hF, {tag, " rel"});
    end
    idle(1'b1, 4'hF, {tag, " after"});
  endtask

  initial begin
    #(PER * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    idle(1'b1, 4'h0, "R1 reset state");
    rst_n = 1'b1;
    idle(1'b1, 4'h0, "R1 idle after reset");

    dma(1'b0, 1'b0, 3'd1, 1'b0, 4'h0, 32'h0000_00A5, 16'h0, 4'b0001, 4'b0000, "R5 R6 R9 read1");
    dma(1'b0, 1'b0, 3'd2, 1'b1, 4'h1, 32'h0000_3C7E, 16'h0002, 4'b0000, 4'b0000, "R5 R8 R11 read2");
    dma(1'b1, 1'b0, 3'd7, 1'b1, 4'h3, 32'h1234_5678, 16'h0100, 4'b0000, 4'b1000, "R7 R9 R11 write4");
    dma(1'b1, 1'b0, 3'd5, 1'b1, 4'h1, 32'h0000_BEEF, 16'h0, 4'b0001, 4'b0000, "R10 write early");
    dma(1'b0, 1'b0, 3'd6, 1'b1, 4'h3, 32'hCAFE_F00D, 16'h0, 4'b0000, 4'b0010, "R10 read early");
    dma(1'b0, 1'b0, 3'd4, 1'b0, 4'h0, 32'h0000_0011, 16'h0, 4'b0000, 4'b0000, "R3 channel 4");
    dma(1'b1, 1'b0, 3'd3, 1'b0, 4'h0, 32'h0000_0022, 16'h0, 4'b0000, 4'b0000, "R3 not requested");
    dma(1'b0, 1'b0, 3'd1, 1'b0, 4'h2, 32'h0000_0033, 16'h0, 4'b0000, 4'b0000, "R4 size 10");
    dma(1'b1, 1'b0, 3'd1, 1'b0, 4'hD, 32'h0000_9A44, 16'h0, 4'b0000, 4'b0000, "R4 size upper bits");
    dma(1'b1, 1'b1, 3'd2, 1'b1, 4'h0, 32'h0000_0066, 16'h0, 4'b0000, 4'b0000, "R2 cyctype bit0");

    idle(1'b0, 4'h0, "R2 non-DMA");
    idle(1'b1, 4'h0, "R2 non-DMA");
    for (int k = 0; k < 8; k++) idle(1'b1, 4'(4'h8 + k), "R2 non-DMA ignored");

    idle(1'b0, 4'h3, "R2 long frame");
    dma(1'b0, 1'b0, 3'd5, 1'b0, 4'h0, 32'h0000_0081, 16'h0, 4'b0000, 4'b0000, "R2 long frame read");

    idle(1'b0, 4'h0, "R12 abort");
    idle(1'b1, 4'h8, "R12 abort");
    idle(1'b1, 4'h1, "R12 abort");
    idle(1'b1, 4'h0, "R12 abort");
    idle(1'b1, 4'h4, "R12 abort");
    idle(1'b1, 4'h2, "R12 abort");
    idle(1'b1, 4'hF, "R12 abort");
    idle(1'b1, 4'hF, "R12 abort");
    step(1'b1, 4'hF, 1'b0, 1'b1, 4'h5, 1'b0, 8'h00, 1'b0, 1'b0, "R12 wait before abort");
    step(1'b0, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b0, 1'b0, "R12 release on frame");
    for (int k = 0; k < 4; k++) idle(1'b1, 4'hF, "R12 idle after abort");
    dma(1'b1, 1'b0, 3'd6, 1'b0, 4'h1, 32'h0000_5AC3, 16'h0030, 4'b0000, 4'b0000, "R8 R12 write after abort");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule